// File: doc/BRIEF.md
# Priority Pin Crossbar Allocator

This block places a fixed, ranked list of seventeen peripheral signals onto a bank of general-purpose pins. The default bank is three 8-bit ports, giving 24 pins. Pins are numbered port × 8 + bit, so port 0 holds pins 0–7, port 1 holds pins 8–15 and port 2 holds pins 16–23.

Software supplies the following:
- an enable bit for each signal;
- a mask of pins to pass over;
- a mask of pins that physically exist;
- a flag that selects 4-wire SPI.

The block works out the allocation combinationally from that configuration, so a new allocation appears as soon as the configuration changes. The result is a function code for every pin. The selected peripheral drives the pin's output data and output enable. Pins with no function fall back to a GPIO output latch. In the other direction, each peripheral input is fed from the pin it was given.

The two UART signals do not take part in the search. Each one is pinned to a fixed pin. Every other enabled signal, in rank order, takes the lowest pin that is still free. When the pins run out, the signals that got no pin are left without one and a sticky flag records the shortfall.

Top module: `pin_crossbar`

## Requirements
- R1: Resources and their codes follow the rank order, highest first. The codes are UART transmit = 1, UART receive = 2, SPI clock = 3, SPI master-in = 4, SPI master-out = 5, SPI slave-select = 6, I2C data = 7, I2C clock = 8, comparator = 9, comparator async = 10, system clock = 11, capture/compare 0/1/2 = 12/13/14, counter clock = 15, timer 0 = 16, timer 1 = 17. Enable bit i of `fn_en` enables the resource whose code is i+1. `pin_sel` carries 5 bits per pin, with pin p at bits [5p+4:5p].
- R2: Each enabled resource with code 3 or higher is placed in rank order on the lowest-numbered free pin, where pin = port × 8 + bit.
- R3: While enabled, UART transmit is fixed on pin 4 and UART receive is fixed on pin 5. These pins are reserved before the search starts, and they are claimed even if their skip or availability bit would exclude them.
- R4: A pin carries at most one resource, and a pin that has already been placed is passed over by every later resource.
- R5: A pin whose `skip_mask` bit is 1 is never given to a searched resource.
- R6: A pin whose `pin_avail` bit is 0 is never given to a searched resource.
- R7: The SPI slave-select resource (code 6) claims a pin only while `spi_4wire` is 1. Otherwise it consumes no pin and the later resources move down.
- R8: An enabled resource that finds no free pin gets no pin. `alloc_ovf` then rises at the next clock edge and stays at 1 until reset.
- R9: An assigned pin drives `pin_out` and `pin_oe` from its resource's `periph_out` and `periph_oe` bits. A resource's `periph_in` bit reads its pin's `pin_in`, and reads 1 when the resource has no pin.
- R10: A pin with no resource carries code 0 and drives `gpio_out` and `gpio_oe`.
- R11: During reset, `alloc_ovf` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the overflow flag |
| rst_n | input | 1 | Active-low asynchronous reset |
| fn_en | input | 17 | Enable for each resource, bit i = code i+1 |
| spi_4wire | input | 1 | SPI 4-wire mode; enables the slave-select pin |
| skip_mask | input | 24 | 1 = pin excluded from the search |
| pin_avail | input | 24 | 1 = pin exists on this variant |
| gpio_out | input | 24 | GPIO output latch values |
| gpio_oe | input | 24 | GPIO output enables |
| periph_out | input | 17 | Output data from each resource |
| periph_oe | input | 17 | Output enable from each resource |
| pin_in | input | 24 | Input values sampled at the pins |
| pin_sel | output | 120 | Function code per pin, 5 bits each |
| pin_out | output | 24 | Output data per pin |
| pin_oe | output | 24 | Output enable per pin |
| periph_in | output | 17 | Input value routed back to each resource |
| alloc_ovf | output | 1 | Sticky flag: some enabled resource got no pin |

## Verification
The bench builds the block with its default parameters: three ports of eight pins and the UART pair on pins 4 and 5. At that size a skip mask that leaves only four pins open makes the full set of seventeen resources overflow, which exercises the sticky flag and the idle-high inputs. An availability mask with a gap across the upper port forces the search to jump to the last pin. Setting the skip bits over pins 4 and 5 shows that the fixed UART pair still claims them.

// File: rtl/pin_crossbar.sv
module pin_crossbar #(
  parameter int NPORTS = 3,
  parameter int PORT_W = 8,
  parameter int TX_PIN = 4,
  parameter int RX_PIN = 5
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [16:0]                           fn_en,
  input  logic                                  spi_4wire,
  input  logic [NPORTS*PORT_W-1:0]              skip_mask,
  input  logic [NPORTS*PORT_W-1:0]              pin_avail,
  input  logic [NPORTS*PORT_W-1:0]              gpio_out,
  input  logic [NPORTS*PORT_W-1:0]              gpio_oe,
  input  logic [16:0]                           periph_out,
  input  logic [16:0]                           periph_oe,
  input  logic [NPORTS*PORT_W-1:0]              pin_in,
  output logic [NPORTS*PORT_W*5-1:0]            pin_sel,
  output logic [NPORTS*PORT_W-1:0]              pin_out,
  output logic [NPORTS*PORT_W-1:0]              pin_oe,
  output logic [16:0]                           periph_in,
  output logic                                  alloc_ovf
);
  localparam int NPINS   = NPORTS * PORT_W;
  localparam int NFN     = 17;
  localparam int CW      = 5;
  localparam int PW      = $clog2(NPINS);
  localparam int NSS_IDX = 5;

  logic [CW-1:0]  sel     [NPINS];
  logic [PW-1:0]  res_pin [NFN];
  logic [NFN-1:0] res_has;
  logic           miss;

  always_comb begin
    logic [NPINS-1:0] taken;
    logic             found;
    taken   = skip_mask | ~pin_avail;
    res_has = '0;
    miss    = 1'b0;
    found   = 1'b0;
    for (int p = 0; p < NPINS; p++) sel[p] = '0;
    for (int r = 0; r < NFN; r++) res_pin[r] = '0;
    if (fn_en[0]) begin
      taken[TX_PIN] = 1'b1;
      sel[TX_PIN]   = CW'(1);
      res_pin[0]    = PW'(TX_PIN);
      res_has[0]    = 1'b1;
    end
    if (fn_en[1]) begin
      taken[RX_PIN] = 1'b1;
      sel[RX_PIN]   = CW'(2);
      res_pin[1]    = PW'(RX_PIN);
      res_has[1]    = 1'b1;
    end
    for (int r = 2; r < NFN; r++) begin
      if (fn_en[r] && (r != NSS_IDX || spi_4wire)) begin
        found = 1'b0;
        for (int p = 0; p < NPINS; p++) begin
          if (!found && !taken[p]) begin
            found      = 1'b1;
            taken[p]   = 1'b1;
            sel[p]     = CW'(r + 1);
            res_pin[r] = PW'(p);
            res_has[r] = 1'b1;
          end
        end
        if (!found) miss = 1'b1;
      end
    end
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic [CW-1:0] src;
    assign src               = sel[p] - CW'(1);
    assign pin_sel[p*CW +: CW] = sel[p];
    assign pin_out[p] = (sel[p] == '0) ? gpio_out[p] : periph_out[src];
    assign pin_oe[p]  = (sel[p] == '0) ? gpio_oe[p]  : periph_oe[src];

    logic uart_here;
    assign uart_here = (p == TX_PIN && fn_en[0]) || (p == RX_PIN && fn_en[1]);

    assert_skip_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
      skip_mask[p] && !uart_here |-> pin_sel[p*CW +: CW] == '0);
    assert_absent_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !pin_avail[p] && !uart_here |-> pin_sel[p*CW +: CW] == '0);
  end

  for (genvar r = 0; r < NFN; r++) begin : g_res
    assign periph_in[r] = res_has[r] ? pin_in[res_pin[r]] : 1'b1;

    logic [NPINS-1:0] hit;
    always_comb
      for (int p = 0; p < NPINS; p++) hit[p] = (pin_sel[p*CW +: CW] == CW'(r + 1));

    assert_single_pin_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(hit) <= 1);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    alloc_ovf <= 1'b0;
    else if (miss) alloc_ovf <= 1'b1;

  assert_uart_tx_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fn_en[0] |-> pin_sel[TX_PIN*CW +: CW] == CW'(1));
  assert_uart_rx_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fn_en[1] |-> pin_sel[RX_PIN*CW +: CW] == CW'(2));
  assert_nss_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_4wire |-> !g_res[NSS_IDX].hit);
  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_ovf |=> alloc_ovf);
endmodule

// File: tb/test_pin_crossbar.sv
module test_pin_crossbar;
  localparam int NP = 24;
  localparam int NF = 17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [16:0] fn_en = '0;
  logic spi_4wire = 1'b0;
  logic [NP-1:0] skip_mask = '0, pin_avail = '1, gpio_out = '0, gpio_oe = '0, pin_in = '0;
  logic [16:0] periph_out = '0, periph_oe = '0;
  logic [NP*5-1:0] pin_sel;
  logic [NP-1:0] pin_out, pin_oe;
  logic [16:0] periph_in;
  logic alloc_ovf;

  always #4 clk = ~clk;

  pin_crossbar i_pin_crossbar (
    .clk(clk), .rst_n(rst_n), .fn_en(fn_en), .spi_4wire(spi_4wire),
    .skip_mask(skip_mask), .pin_avail(pin_avail), .gpio_out(gpio_out),
    .gpio_oe(gpio_oe), .periph_out(periph_out), .periph_oe(periph_oe),
    .pin_in(pin_in), .pin_sel(pin_sel), .pin_out(pin_out), .pin_oe(pin_oe),
    .periph_in(periph_in), .alloc_ovf(alloc_ovf));

  typedef struct {
    int          kind;
    int          idx;
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t q[$];
  event  check_ev;
  int    n_run = 0, n_fail = 0;
  bit    done = 0;
  logic  exp_ovf = 1'b0;

  int  m_sel [NP];
  int  m_pin [NF];
  bit  m_has [NF];
  bit  m_miss;

  task automatic model();
    logic [NP-1:0] busy;
    busy = skip_mask | ~pin_avail;
    m_miss = 0;
    for (int p = 0; p < NP; p++) m_sel[p] = 0;
    for (int r = 0; r < NF; r++) begin m_has[r] = 0; m_pin[r] = 0; end
    if (fn_en[0]) begin busy[4] = 1; m_sel[4] = 1; m_has[0] = 1; m_pin[0] = 4; end
    if (fn_en[1]) begin busy[5] = 1; m_sel[5] = 2; m_has[1] = 1; m_pin[1] = 5; end
    for (int r = 2; r < NF; r++) begin
      if (fn_en[r] && (r != 5 || spi_4wire)) begin
        int hit;
        hit = -1;
        for (int p = 0; p < NP; p++)
          if (hit < 0 && !busy[p]) hit = p;
        if (hit < 0) m_miss = 1;
        else begin busy[hit] = 1; m_sel[hit] = r + 1; m_has[r] = 1; m_pin[r] = hit; end
      end
    end
  endtask

  task automatic push(int kind, int idx, logic [31:0] exp, string req);
    item_t it;
    it.kind = kind; it.idx = idx; it.exp = exp; it.req = req;
    q.push_back(it);
  endtask

  task automatic apply(logic [16:0] en, logic spi4, logic [NP-1:0] skip,
                       logic [NP-1:0] avail, string req);
    @(negedge clk);
    fn_en = en; spi_4wire = spi4; skip_mask = skip; pin_avail = avail;
    model();
    @(posedge clk);
    if (rst_n && m_miss) exp_ovf = 1'b1;
    #2;
    for (int p = 0; p < NP; p++) begin
      int s;
      s = m_sel[p];
      push(0, p, 32'(s), req);
      push(1, p, 32'(s == 0 ? gpio_out[p] : periph_out[s-1]), "R9/R10");
      push(2, p, 32'(s == 0 ? gpio_oe[p] : periph_oe[s-1]), "R9/R10");
    end
    for (int r = 0; r < NF; r++)
      push(3, r, 32'(m_has[r] ? pin_in[m_pin[r]] : 1'b1), "R9");
    push(4, 0, 32'(exp_ovf), rst_n ? "R8" : "R11");
    -> check_ev;
    #1;
  endtask

  initial begin : monitor
    forever begin
      @(check_ev);
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = q.pop_front();
        case (it.kind)
          0: act = 32'(pin_sel[it.idx*5 +: 5]);
          1: act = 32'(pin_out[it.idx]);
          2: act = 32'(pin_oe[it.idx]);
          3: act = 32'(periph_in[it.idx]);
          default: act = 32'(alloc_ovf);
        endcase
        n_run++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s kind=%0d idx=%0d actual=%0d expected=%0d",
                   it.req, it.kind, it.idx, act, it.exp);
        end
      end
    end
  end

  initial begin : driver
    gpio_out = 24'hA5C3_96; gpio_oe = 24'h0F0F_33;
    periph_out = 17'h1_5A3C; periph_oe = 17'h0_F0A5;
    pin_in = 24'h3C_96A5;
    // R11: reset state, nothing enabled
    apply('0, 1'b0, '0, '1, "R11/R10");
    rst_n = 1'b1;
    // R1 R2 R3: all enabled, 3-wire SPI
    apply(17'h1FFFF, 1'b0, '0, '1, "R1/R2/R3");
    // R7: 4-wire SPI adds slave-select
    apply(17'h1FFFF, 1'b1, '0, '1, "R7");
    // R5 R4: skip pins 2,3,8,9
    pin_in = 24'hC3_5A69; periph_out = 17'h0_A5C3;
    apply(17'h1FFFF, 1'b1, 24'h00_030C, '1, "R5/R4");
    // R6: upper port absent except pin 23, low pins mostly skipped, no UART
    apply(17'h1FFFC, 1'b0, 24'h00_FFF0, 24'h80_FFFF, "R6/R8");
    // R3: UART pins claimed despite skip; most pins skipped -> overflow
    apply(17'h1FFFF, 1'b1, 24'hFF_FFF0, '1, "R3/R8");
    // R8: sticky after configuration recovers
    apply(17'h00004, 1'b0, '0, '1, "R8/R2");
    // R10 R9: only GPIO
    gpio_out = 24'h5A_0FF0; gpio_oe = 24'hF0_A55A;
    apply('0, 1'b0, '0, '1, "R10/R9");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : watchdog
    #(200000 * 8);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule